// File: doc/BRIEF.md
# Post-Update Store Address Unit

This unit is the address and data path for a family of store operations that write memory at the unmodified value of a base register and then return an updated address to that same register. A decoded request carries an access size, an addressing form, the base, index and source operand values, a signed displacement field and the number of the base register. From these, the unit forms a 64-bit little-endian memory write with byte enables. It also computes the updated base value, which is the effective address.

The memory write leaves on a valid/ready port. The writeback of the base register is offered in the same cycle the memory side accepts the store, and never earlier. The unit takes one request at a time and reports busy until its store is taken. Two illegal cases produce a one-cycle flag and no memory or register activity: a base register number of zero, and an access that would straddle an 8-byte boundary. No other state or status is changed.

Top module: `pstore_agu`

## Requirements
- R1: The memory write address equals the base operand exactly as presented, not the updated address.
- R2: Form code 0 adds the 16-bit displacement, sign-extended to 64 bits, to the base operand, and writes that sum back.
- R3: Form code 1 appends two zero bits to the low 14 displacement bits, sign-extends the 16-bit result and adds it to the base. The upper displacement bits are ignored.
- R4: Form code 2 writes back the base plus the index operand, with the sum wrapping modulo 2^64.
- R5: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The least-significant bytes of the source are placed starting at lane addr[2:0], where byte lane k is data bits 8k+7..8k. Byte enables are set exactly for those lanes, and all other data bits are zero.
- R6: A base register number of 0, or form code 3, raises the form-error flag for exactly one cycle, starting the cycle after the request. No memory write, writeback or busy results.
- R7: When a legal-form request has addr[2:0] plus its size in bytes greater than 8, the alignment-error flag is raised for one cycle with no write, writeback or busy. The form error takes precedence.
- R8: While the memory request is valid and not ready, its address, data and enables hold steady.
- R9: The writeback is valid exactly in a cycle where the memory request is valid and ready. It carries the base register number and the effective address.
- R10: Busy is high from the cycle after acceptance until the cycle after the store is taken. Requests presented while busy are ignored.
- R11: Reset clears every pending request, flag and busy indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_size | input | 2 | Access size code |
| req_form | input | 2 | Addressing form code |
| req_disp | input | 16 | Displacement field |
| req_base | input | 64 | Base register value |
| req_index | input | 64 | Index register value |
| req_src | input | 64 | Source register value |
| req_base_num | input | 5 | Base register number |
| busy | output | 1 | A store is pending |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write address |
| mem_data | output | 64 | Lane-aligned write data |
| mem_be | output | 8 | Byte enables |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_num | output | 5 | Writeback register number |
| wb_data | output | 64 | Updated base value |
| err_form | output | 1 | Invalid-form pulse |
| err_align | output | 1 | Boundary-crossing pulse |

## Verification
Random requests span all three forms with random 64-bit bases, indexes and displacements. Comparing the write address against the writeback value separates the un-incremented access address from the summed one. Negative displacements at the field extremes show whether sign extension happens before or after the two-bit shift in the scaled form. Directed cases put each size at the last lane that fits and at the first lane that crosses, to separate a correct boundary test from an off-by-one. Further cases set the register number to zero, use the reserved form, and pair an invalid form with misalignment to fix the flag priority. Random memory stalls, with competing requests presented during them, show that the request holds steady and that new requests are not taken while busy.

// File: rtl/pstore_pkg.sv
package pstore_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } st_size_e;

    typedef enum logic [1:0] {
        FM_DISP   = 2'd0,
        FM_SCALED = 2'd1,
        FM_INDEX  = 2'd2,
        FM_RSVD   = 2'd3
    } st_form_e;

endpackage

// File: rtl/pstore_ea.sv
module pstore_ea
    import pstore_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int DISP_W  = 16,
    parameter int SDISP_W = 14
) (
    input  st_form_e              form,
    input  logic [XLEN-1:0]       base,
    input  logic [XLEN-1:0]       index,
    input  logic [DISP_W-1:0]     disp,
    output logic [XLEN-1:0]       ea
);
    localparam int SPAD = XLEN - SDISP_W - 2;
    localparam int DPAD = XLEN - DISP_W;

    logic [XLEN-1:0] offset;

    always_comb begin
        unique case (form)
            FM_DISP:   offset = {{DPAD{disp[DISP_W-1]}}, disp};
            FM_SCALED: offset = {{SPAD{disp[SDISP_W-1]}}, disp[SDISP_W-1:0], 2'b00};
            FM_INDEX:  offset = index;
            default:   offset = '0;
        endcase
        ea = base + offset;
    end

    // R3
    always_comb begin
        if (form == FM_SCALED) begin
            scaled_word_step_chk: assert (((ea - base) & 64'd3) == 64'd0);
        end
    end

endmodule

// File: rtl/pstore_lane.sv
module pstore_lane
    import pstore_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  st_size_e                    size,
    input  logic [$clog2(XLEN/8)-1:0]   addr_lo,
    input  logic [XLEN-1:0]             src,
    output logic [XLEN-1:0]             data,
    output logic [XLEN/8-1:0]           be,
    output logic                        misalign
);
    localparam int NBYTE = XLEN / 8;
    localparam int OFS_W = $clog2(NBYTE);

    logic [OFS_W:0]    nbytes;
    logic [OFS_W:0]    span_end;
    logic [XLEN-1:0]   keep;
    logic [XLEN-1:0]   lane_mask;

    always_comb begin
        nbytes   = (OFS_W+1)'(1) << size;
        span_end = {1'b0, addr_lo} + nbytes;
        misalign = span_end > (OFS_W+1)'(NBYTE);
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign keep[8*b +: 8] = ((OFS_W+1)'(b) < nbytes) ? 8'hFF : 8'h00;
        assign be[b] = ((OFS_W+1)'(b) >= {1'b0, addr_lo}) && ((OFS_W+1)'(b) < span_end);
        assign lane_mask[8*b +: 8] = {8{be[b]}};
    end

    assign data = (src & keep) << {addr_lo, 3'b000};

    // R5
    always_comb begin
        if (!misalign) begin
            lane_confined_chk: assert ((data & ~lane_mask) == '0);
        end
    end

endmodule

// File: rtl/pstore_agu.sv
module pstore_agu
    import pstore_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int DISP_W  = 16,
    parameter int SDISP_W = 14,
    parameter int RN_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_size,
    input  logic [1:0]           req_form,
    input  logic [DISP_W-1:0]    req_disp,
    input  logic [XLEN-1:0]      req_base,
    input  logic [XLEN-1:0]      req_index,
    input  logic [XLEN-1:0]      req_src,
    input  logic [RN_W-1:0]      req_base_num,
    output logic                 busy,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [XLEN-1:0]      mem_addr,
    output logic [XLEN-1:0]      mem_data,
    output logic [XLEN/8-1:0]    mem_be,
    output logic                 wb_valid,
    output logic [RN_W-1:0]      wb_num,
    output logic [XLEN-1:0]      wb_data,
    output logic                 err_form,
    output logic                 err_align
);
    localparam int NBYTE = XLEN / 8;
    localparam int OFS_W = $clog2(NBYTE);

    typedef struct packed {
        logic               pend;
        logic [XLEN-1:0]    addr;
        logic [XLEN-1:0]    data;
        logic [NBYTE-1:0]   be;
        logic [XLEN-1:0]    ea;
        logic [RN_W-1:0]    rnum;
        logic [1:0]         size;
        logic               err_form;
        logic               err_align;
    } agu_state_t;

    agu_state_t st_d, st_q;

    st_form_e          form_in;
    st_size_e          size_in;
    logic [XLEN-1:0]   ea_calc;
    logic [XLEN-1:0]   lane_data;
    logic [NBYTE-1:0]  lane_be;
    logic              lane_mis;
    logic              accept;
    logic              bad_form;

    assign form_in = st_form_e'(req_form);
    assign size_in = st_size_e'(req_size);

    pstore_ea #(
        .XLEN    (XLEN),
        .DISP_W  (DISP_W),
        .SDISP_W (SDISP_W)
    ) u_ea (
        .form  (form_in),
        .base  (req_base),
        .index (req_index),
        .disp  (req_disp),
        .ea    (ea_calc)
    );

    pstore_lane #(
        .XLEN (XLEN)
    ) u_lane (
        .size     (size_in),
        .addr_lo  (req_base[OFS_W-1:0]),
        .src      (req_src),
        .data     (lane_data),
        .be       (lane_be),
        .misalign (lane_mis)
    );

    always_comb begin
        st_d           = st_q;
        st_d.err_form  = 1'b0;
        st_d.err_align = 1'b0;
        accept         = req_valid && !st_q.pend;
        bad_form       = (req_base_num == '0) || (form_in == FM_RSVD);

        if (st_q.pend && mem_ready) begin
            st_d.pend = 1'b0;
        end

        if (accept) begin
            if (bad_form) begin
                st_d.err_form = 1'b1;
            end else if (lane_mis) begin
                st_d.err_align = 1'b1;
            end else begin
                st_d.pend = 1'b1;
                st_d.addr = req_base;
                st_d.data = lane_data;
                st_d.be   = lane_be;
                st_d.ea   = ea_calc;
                st_d.rnum = req_base_num;
                st_d.size = req_size;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.pend;
    assign mem_valid = st_q.pend;
    assign mem_addr  = st_q.addr;
    assign mem_data  = st_q.data;
    assign mem_be    = st_q.be;
    assign wb_valid  = st_q.pend && mem_ready;
    assign wb_num    = st_q.rnum;
    assign wb_data   = st_q.ea;
    assign err_form  = st_q.err_form;
    assign err_align = st_q.err_align;

    // R8
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

    // R5
    enable_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == (1 << st_q.size)));

    // R6
    error_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_form || err_align) |-> (!mem_valid && !(err_form && err_align)));

    // R10
    busy_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R9
    wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

endmodule

// File: tb/pstore_agu_bench.sv
module pstore_agu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_form = '0;
    logic [15:0] req_disp = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_index = '0;
    logic [63:0] req_src = '0;
    logic [4:0]  req_base_num = '0;
    logic        mem_ready = 1'b0;
    logic        busy, mem_valid, wb_valid, err_form, err_align;
    logic [63:0] mem_addr, mem_data, wb_data;
    logic [7:0]  mem_be;
    logic [4:0]  wb_num;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pstore_agu u_pstore_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .req_form(req_form), .req_disp(req_disp), .req_base(req_base),
        .req_index(req_index), .req_src(req_src), .req_base_num(req_base_num),
        .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .wb_valid(wb_valid), .wb_num(wb_num), .wb_data(wb_data),
        .err_form(err_form), .err_align(err_align)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R10 watchdog expired: actual hung expected done");
            summary();
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ea(logic [1:0] f, logic [63:0] b, logic [63:0] x, logic [15:0] d);
        case (f)
            2'd0: return b + {{48{d[15]}}, d};
            2'd1: return b + {{48{d[13]}}, d[13:0], 2'b00};
            2'd2: return b + x;
            default: return b;
        endcase
    endfunction

    function automatic int nb(logic [1:0] s);
        return 1 << s;
    endfunction

    function automatic bit exp_mis(logic [1:0] s, logic [63:0] b);
        return (int'(b[2:0]) + nb(s)) > 8;
    endfunction

    function automatic logic [7:0] exp_be(logic [1:0] s, logic [63:0] b);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++)
            r[k] = (k >= int'(b[2:0])) && (k < int'(b[2:0]) + nb(s));
        return r;
    endfunction

    function automatic logic [63:0] exp_data(logic [1:0] s, logic [63:0] b, logic [63:0] v);
        logic [63:0] m = v;
        for (int k = 0; k < 8; k++)
            if (k >= nb(s)) m[8*k +: 8] = 8'h00;
        return m << (8 * int'(b[2:0]));
    endfunction

    function automatic string form_tag(logic [1:0] f);
        case (f)
            2'd0: return "R2";
            2'd1: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_txn(logic [1:0] s, logic [1:0] f, logic [15:0] d, logic [63:0] b,
                           logic [63:0] x, logic [63:0] v, logic [4:0] rn, int stall, bit poke);
        bit badf;
        bit mis;
        @(negedge clk);
        req_size = s; req_form = f; req_disp = d; req_base = b;
        req_index = x; req_src = v; req_base_num = rn; req_valid = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        badf = (rn == 5'd0) || (f == 2'd3);
        mis  = exp_mis(s, b);
        if (badf || mis) begin
            chk("R6 form flag", 64'(err_form), 64'(badf));
            chk("R7 align flag", 64'(err_align), 64'(!badf && mis));
            chk("R6 R7 no write", 64'(mem_valid), 64'd0);
            chk("R6 R7 not busy", 64'(busy), 64'd0);
            mem_ready = 1'b1;
            #1;
            chk("R6 R7 no writeback", 64'(wb_valid), 64'd0);
            @(negedge clk);
            mem_ready = 1'b0;
            chk("R6 flag pulse", 64'(err_form), 64'd0);
            chk("R7 flag pulse", 64'(err_align), 64'd0);
            return;
        end
        chk("R1 valid", 64'(mem_valid), 64'd1);
        chk("R10 busy set", 64'(busy), 64'd1);
        chk("R1 address", mem_addr, b);
        chk("R5 enables", 64'(mem_be), 64'(exp_be(s, b)));
        chk("R5 data", mem_data, exp_data(s, b, v));
        chk("R9 no early writeback", 64'(wb_valid), 64'd0);
        for (int i = 0; i < stall; i++) begin
            if (poke && i == 0) begin
                req_base = ~b; req_src = ~v; req_base_num = rn ^ 5'h1F; req_valid = 1'b1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8 valid held", 64'(mem_valid), 64'd1);
            chk("R8 R10 address held", mem_addr, b);
            chk("R8 data held", mem_data, exp_data(s, b, v));
            chk("R9 stalled no writeback", 64'(wb_valid), 64'd0);
        end
        mem_ready = 1'b1;
        #1;
        chk("R9 writeback strobe", 64'(wb_valid), 64'd1);
        chk("R9 writeback number", 64'(wb_num), 64'(rn));
        chk(form_tag(f), wb_data, exp_ea(f, b, x, d));
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R10 busy cleared", 64'(busy), 64'd0);
        chk("R10 valid cleared", 64'(mem_valid), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        #(CLK_PERIOD * 2 + 2);
        // R11 reset state
        chk("R11 valid", 64'(mem_valid), 64'd0);
        chk("R11 busy", 64'(busy), 64'd0);
        chk("R11 flags", 64'({err_form, err_align, wb_valid}), 64'd0);
        rst_n = 1'b1;

        // directed corners
        run_txn(2'd0, 2'd0, 16'h8000, 64'h0000_0000_0001_0000, 64'd0, 64'h1122334455667788, 5'd3, 0, 0);
        run_txn(2'd1, 2'd1, 16'hE000, 64'h0000_0000_0000_1006, 64'd0, 64'hAAAA_BBBB_CCCC_DDEE, 5'd7, 2, 1);
        run_txn(2'd1, 2'd1, 16'h1FFF, 64'h10, 64'd0, 64'h5A5A, 5'd1, 0, 0);
        run_txn(2'd1, 2'd0, 16'h7FFF, 64'h7, 64'd0, 64'h5A5A, 5'd1, 0, 0);
        run_txn(2'd0, 2'd0, 16'h0001, 64'h7, 64'd0, 64'hFFFF_FFFF_FFFF_FFC3, 5'd2, 1, 0);
        run_txn(2'd2, 2'd2, 16'd0, 64'h4, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0123456789ABCDEF, 5'd31, 3, 1);
        run_txn(2'd2, 2'd2, 16'd0, 64'h5, 64'd8, 64'h1, 5'd4, 0, 0);
        run_txn(2'd3, 2'd2, 16'd0, 64'h8, 64'd8, 64'hDEADBEEF_CAFEF00D, 5'd9, 1, 0);
        run_txn(2'd3, 2'd0, 16'd8, 64'h9, 64'd0, 64'h1, 5'd9, 0, 0);
        run_txn(2'd0, 2'd0, 16'd4, 64'h100, 64'd0, 64'hFF, 5'd0, 0, 0);
        run_txn(2'd0, 2'd3, 16'd4, 64'h100, 64'd0, 64'hFF, 5'd6, 0, 0);
        run_txn(2'd3, 2'd1, 16'd4, 64'h103, 64'd0, 64'hFF, 5'd0, 0, 0);

        // R11 reset while a store is pending
        @(negedge clk);
        req_size = 2'd0; req_form = 2'd0; req_base = 64'h40; req_base_num = 5'd5; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 pending before reset", 64'(busy), 64'd1);
        rst_n = 1'b0;
        #1;
        chk("R11 reset clears busy", 64'(busy), 64'd0);
        chk("R11 reset clears valid", 64'(mem_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // constrained random
        for (int t = 0; t < 400; t++) begin
            logic [1:0] f;
            f = 2'($urandom % 3);
            if (($urandom % 20) == 0) f = 2'd3;
            run_txn(2'($urandom), f, 16'($urandom), {$urandom, $urandom},
                    {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom),
                    int'($urandom % 4), bit'($urandom % 2));
        end

        summary();
        $finish;
    end

endmodule